// File: doc/BRIEF.md
# Receiver Staged Reset Sequencer

This block drives the internal resets of a serial receiver in a timed cascade. Four reset outputs cover the clock-recovery stage, the out-of-band signal detector, the receive datapath and the elastic buffer. A free-running 1 µs tick, divided down from the system clock, sets every interval. A full request comes from either the global tile reset or the receiver reset input. Both may be asynchronous and are synchronized before use. A full request asserts all four outputs and then releases them one after another, one tick apart, starting with clock recovery.

A third request input handles electrical idle. It acts only while its enable input is high, and it pulses only the clock-recovery reset, leaving the other three low. While a request is held, the sequence stays in its first stage. A new full request restarts a running sequence. `busy_o` is high while a sequence is active, and `done_o` marks the end of each sequence. Clock frequency, minimum clock-recovery hold and synchronizer depth are parameters.

Top module: `rxrst_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, all four reset outputs and `busy_o` are high and `done_o` is low. A full sequence then runs by itself.
- R2: A request at any request input reaches the sequencer through a SYNC_STAGES-flop synchronizer. The outputs respond on the third rising edge after the request is applied (default depth of 2) and not before.
- R3: While a full request is held high, all four reset outputs stay high.
- R4: After a request is released, the clock-recovery reset falls at least CDR_MIN_US µs later and at most CDR_MIN_US+1 µs later plus SYNC_STAGES+2 cycles. Here 1 µs is CLK_MHZ clock cycles.
- R5: In a full sequence, the out-of-band reset falls exactly CLK_MHZ cycles after the clock-recovery reset falls.
- R6: The datapath reset falls exactly CLK_MHZ cycles after the out-of-band reset falls.
- R7: The buffer reset falls exactly CLK_MHZ cycles after the datapath reset falls.
- R8: `done_o` is high for exactly one cycle, in the cycle the last reset of the sequence falls. In that same cycle `busy_o` is low. `busy_o` is high whenever any reset output is high.
- R9: With `idle_en_i` high and no full sequence running, an idle request asserts the clock-recovery reset only. The other three outputs stay low throughout, and `done_o` pulses when the clock-recovery reset falls.
- R10: With `idle_en_i` low, `idle_req_i` has no effect: every output stays low.
- R11: An enabled idle request that arrives during a full sequence is ignored, and the cascade timing is unchanged.
- R12: A full request during a running sequence re-asserts all four outputs with the latency of R2 and restarts the sequence from its first stage.
- R13: The global tile reset acts exactly like the receiver reset input, asserting all four outputs, including clock recovery.
- R14: Release order holds at all times: the datapath reset is never low while the out-of-band reset is high, and the buffer reset is never low while the datapath reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tile_rst_i | input | 1 | Global tile reset request, asynchronous |
| cdr_req_i | input | 1 | Receiver reset request, asynchronous |
| idle_req_i | input | 1 | Electrical-idle reset request, asynchronous |
| idle_en_i | input | 1 | Enable for the idle request |
| cdr_rst_o | output | 1 | Clock-recovery reset |
| oob_rst_o | output | 1 | Out-of-band detector reset |
| dp_rst_o | output | 1 | Receive datapath reset |
| buf_rst_o | output | 1 | Elastic buffer reset |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A request reaches the outputs on the third rising edge after it is applied. The bench samples one falling edge after that and also confirms that the outputs were still low one edge earlier. The release of clock recovery depends on the free-running tick phase, so the bench checks it against a window measured from the falling edge where the request was released. Each later release is due exactly CLK_MHZ cycles after the one before it. The bench time-stamps every output fall on falling edges, compares the differences with exact values, and checks that `done_o` lands in the same cycle as the final fall.

// File: rtl/rxrst_pkg.sv
package rxrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CDR  = 3'd1,
    ST_OOB  = 3'd2,
    ST_DP   = 3'd3,
    ST_BUF  = 3'd4
  } stage_e;

  typedef struct packed {
    logic cdr;
    logic oob;
    logic dpath;
    logic ebuf;
  } rst_vec_t;

endpackage

// File: rtl/rxrst_sync.sv
module rxrst_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rxrst_tick.sv
module rxrst_tick #(
  parameter int CLK_MHZ = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [CW-1:0] TERM = CW'(CLK_MHZ - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      if (cnt_q == TERM) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
      tick_o <= (cnt_q == TERM);
    end
  end
endmodule

// File: rtl/rxrst_fsm.sv
module rxrst_fsm
  import rxrst_pkg::*;
#(
  parameter int CDR_MIN_US = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     full_req_i,
  input  logic     idle_req_i,
  output rst_vec_t rst_o,
  output logic     busy_o,
  output logic     done_o
);
  // One extra tick covers the partial first interval of the free-running tick.
  localparam int CDR_TICKS = CDR_MIN_US + 1;
  localparam int CW = $clog2(CDR_TICKS + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CDR_TICKS - 1);

  stage_e        stage_q;
  logic          full_q;
  logic [CW-1:0] cnt_q;
  rst_vec_t      rst_q;
  logic          done_q;
  logic          full_running;

  assign full_running = full_q && (stage_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= ST_CDR;
      full_q  <= 1'b1;
      cnt_q   <= '0;
      rst_q   <= '1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (full_req_i) begin
        stage_q <= ST_CDR;
        full_q  <= 1'b1;
        cnt_q   <= '0;
        rst_q   <= '1;
      end else if (idle_req_i && !full_running) begin
        stage_q <= ST_CDR;
        full_q  <= 1'b0;
        cnt_q   <= '0;
        rst_q   <= '{cdr: 1'b1, oob: 1'b0, dpath: 1'b0, ebuf: 1'b0};
      end else if (tick_i) begin
        unique case (stage_q)
          ST_CDR: begin
            if (cnt_q == CNT_LAST) begin
              rst_q.cdr <= 1'b0;
              if (full_q) begin
                stage_q <= ST_OOB;
              end else begin
                stage_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_OOB: begin
            rst_q.oob <= 1'b0;
            stage_q   <= ST_DP;
          end
          ST_DP: begin
            rst_q.dpath <= 1'b0;
            stage_q     <= ST_BUF;
          end
          ST_BUF: begin
            rst_q.ebuf <= 1'b0;
            stage_q    <= ST_IDLE;
            done_q     <= 1'b1;
          end
          default: begin
          end
        endcase
      end
    end
  end

  assign rst_o  = rst_q;
  assign busy_o = (stage_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/rxrst_seq.sv
module rxrst_seq
  import rxrst_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int CDR_MIN_US  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tile_rst_i,
  input  logic cdr_req_i,
  input  logic idle_req_i,
  input  logic idle_en_i,
  output logic cdr_rst_o,
  output logic oob_rst_o,
  output logic dp_rst_o,
  output logic buf_rst_o,
  output logic busy_o,
  output logic done_o
);
  localparam int NREQ = 4;

  logic [NREQ-1:0] req_s;
  logic            tick;
  rst_vec_t        rst_v;

  rxrst_sync #(.WIDTH(NREQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({tile_rst_i, cdr_req_i, idle_req_i, idle_en_i}),
    .sync_o (req_s)
  );

  rxrst_tick #(.CLK_MHZ(CLK_MHZ)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  rxrst_fsm #(.CDR_MIN_US(CDR_MIN_US)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .full_req_i(req_s[3] | req_s[2]),
    .idle_req_i(req_s[1] & req_s[0]),
    .rst_o     (rst_v),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign cdr_rst_o = rst_v.cdr;
  assign oob_rst_o = rst_v.oob;
  assign dp_rst_o  = rst_v.dpath;
  assign buf_rst_o = rst_v.ebuf;
endmodule

// File: rtl/rxrst_seq_chk.sv
module rxrst_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cdr_rst_o,
  input logic oob_rst_o,
  input logic dp_rst_o,
  input logic buf_rst_o,
  input logic busy_o,
  input logic done_o
);
  // R8: the done pulse lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: the sequence is finished in the cycle done is reported
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8: any active reset implies an active sequence
  a_r8_rst_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cdr_rst_o || oob_rst_o || dp_rst_o || buf_rst_o) |-> busy_o);

  // R14: datapath release never precedes out-of-band release
  a_r14_order_dp: assert property (@(posedge clk) disable iff (!rst_n)
    oob_rst_o |-> dp_rst_o);

  // R14: buffer release never precedes datapath release
  a_r14_order_buf: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst_o |-> buf_rst_o);

  // R5: out-of-band reset is released only once clock recovery is released
  a_r5_oob_after_cdr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oob_rst_o) |-> !cdr_rst_o);
endmodule

bind rxrst_seq rxrst_seq_chk u_chk (.*);

// File: tb/rxrst_seq_tb.sv
`timescale 1ns/1ps
module rxrst_seq_tb;
  localparam int CLK_MHZ     = 50;
  localparam int CDR_MIN_US  = 2;
  localparam int SYNC_STAGES = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tile_rst_i = 1'b0, cdr_req_i = 1'b0, idle_req_i = 1'b0, idle_en_i = 1'b0;
  logic cdr_rst_o, oob_rst_o, dp_rst_o, buf_rst_o, busy_o, done_o;

  always #10 clk = ~clk;

  rxrst_seq #(.CLK_MHZ(CLK_MHZ), .CDR_MIN_US(CDR_MIN_US), .SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .tile_rst_i(tile_rst_i), .cdr_req_i(cdr_req_i),
    .idle_req_i(idle_req_i), .idle_en_i(idle_en_i), .cdr_rst_o(cdr_rst_o),
    .oob_rst_o(oob_rst_o), .dp_rst_o(dp_rst_o), .buf_rst_o(buf_rst_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int f_cdr = 0, f_oob = 0, f_dp = 0, f_buf = 0;
  int done_cyc = 0, done_cnt = 0;
  int hi_late = 0, hi_cdr = 0, busy_cnt = 0;
  logic p_cdr = 1'b0, p_oob = 1'b0, p_dp = 1'b0, p_buf = 1'b0, p_done = 1'b0;

  function automatic int exp_gap();
    return CLK_MHZ;
  endfunction
  function automatic int exp_lo();
    return CDR_MIN_US * CLK_MHZ;
  endfunction
  function automatic int exp_hi();
    return (CDR_MIN_US + 1) * CLK_MHZ + SYNC_STAGES + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_cdr && !cdr_rst_o) f_cdr = cyc;
      if (p_oob && !oob_rst_o) f_oob = cyc;
      if (p_dp  && !dp_rst_o)  f_dp  = cyc;
      if (p_buf && !buf_rst_o) f_buf = cyc;
      if (done_o) begin
        done_cyc = cyc;
        done_cnt++;
        if (p_done) chk(1'b0, "R8 done wider than one cycle", 2, 1);
      end
      if (oob_rst_o || dp_rst_o || buf_rst_o) hi_late++;
      if (cdr_rst_o) hi_cdr++;
      if (busy_o) busy_cnt++;
    end
    p_cdr = cdr_rst_o; p_oob = oob_rst_o; p_dp = dp_rst_o; p_buf = buf_rst_o;
    p_done = done_o;
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  task automatic wait_done(input string tag);
    int start = done_cnt;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done_cnt != start) return;
    end
    chk(1'b0, {tag, " sequence did not finish"}, 0, 1);
  endtask

  task automatic check_cascade(input string tag);
    chk(f_oob - f_cdr == exp_gap(), {tag, " R5 oob after cdr"}, f_oob - f_cdr, exp_gap());
    chk(f_dp - f_oob == exp_gap(), {tag, " R6 dp after oob"}, f_dp - f_oob, exp_gap());
    chk(f_buf - f_dp == exp_gap(), {tag, " R7 buf after dp"}, f_buf - f_dp, exp_gap());
    chk(done_cyc == f_buf, {tag, " R8 done with last release"}, done_cyc, f_buf);
    chk(busy_o == 1'b0, {tag, " R8 busy low at done"}, busy_o, 0);
  endtask

  // Full request through tile reset (R13) or receiver reset input.
  task automatic full_req(input bit use_tile, input int hold);
    bit from_idle;
    bit all_hi;
    int rel;
    @(negedge clk);
    from_idle = !busy_o;
    if (use_tile) tile_rst_i = 1'b1; else cdr_req_i = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (from_idle) chk(cdr_rst_o == 1'b0, "R2 no response before sync latency", cdr_rst_o, 0);
    @(posedge clk);
    @(negedge clk);
    all_hi = cdr_rst_o && oob_rst_o && dp_rst_o && buf_rst_o && busy_o;
    chk(all_hi, use_tile ? "R13 tile reset asserts all" : "R2 request asserts all", all_hi, 1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!(cdr_rst_o && oob_rst_o && dp_rst_o && buf_rst_o)) all_hi = 1'b0;
    end
    chk(all_hi, "R3 held while request held", all_hi, 1);
    tile_rst_i = 1'b0; cdr_req_i = 1'b0;
    rel = cyc;
    wait_done("full");
    chk(f_cdr - rel >= exp_lo() && f_cdr - rel <= exp_hi(), "R4 cdr release window",
        f_cdr - rel, exp_lo());
    check_cascade("full");
  endtask

  initial begin
    bit all_hi;
    int rel, snap, snap2, snap3;
    void'($urandom(32'd4711));

    // R1: power-on state
    repeat (4) @(negedge clk);
    all_hi = cdr_rst_o && oob_rst_o && dp_rst_o && buf_rst_o && busy_o && !done_o;
    chk(all_hi, "R1 outputs asserted in reset", all_hi, 1);
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    all_hi = cdr_rst_o && oob_rst_o && dp_rst_o && buf_rst_o && busy_o;
    chk(all_hi, "R1 outputs asserted after reset", all_hi, 1);
    wait_done("R1");
    chk(f_cdr - rel >= exp_lo() && f_cdr - rel <= exp_hi(), "R1 R4 cdr release window",
        f_cdr - rel, exp_lo());
    check_cascade("R1");

    // Directed full requests
    full_req(1'b0, 6);
    full_req(1'b1, 10);

    // R10: idle request without enable
    idle_en_i = 1'b0;
    repeat (6) @(negedge clk);
    snap = hi_cdr; snap2 = hi_late; snap3 = busy_cnt;
    idle_req_i = 1'b1;
    repeat (30) @(negedge clk);
    idle_req_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(hi_cdr == snap && hi_late == snap2 && busy_cnt == snap3, "R10 disabled idle request ignored",
        hi_cdr - snap + busy_cnt - snap3, 0);

    // R9: enabled idle request resets clock recovery only
    idle_en_i = 1'b1;
    repeat (6) @(negedge clk);
    snap2 = hi_late;
    idle_req_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cdr_rst_o && busy_o && !oob_rst_o, "R9 idle asserts cdr only", cdr_rst_o, 1);
    repeat (5) @(negedge clk);
    idle_req_i = 1'b0;
    rel = cyc;
    wait_done("R9");
    chk(f_cdr - rel >= exp_lo() && f_cdr - rel <= exp_hi(), "R9 R4 idle cdr window",
        f_cdr - rel, exp_lo());
    chk(done_cyc == f_cdr, "R9 done at cdr release", done_cyc, f_cdr);
    chk(hi_late == snap2, "R9 other resets stay low", hi_late - snap2, 0);

    // R11: idle request during a full sequence
    @(negedge clk);
    cdr_req_i = 1'b1;
    repeat (4) @(negedge clk);
    cdr_req_i = 1'b0;
    for (int i = 0; i < 400 && cdr_rst_o; i++) @(negedge clk);
    snap = hi_cdr;
    idle_req_i = 1'b1;
    repeat (10) @(negedge clk);
    idle_req_i = 1'b0;
    wait_done("R11");
    chk(hi_cdr == snap, "R11 idle request ignored mid-sequence", hi_cdr - snap, 0);
    check_cascade("R11");

    // R12: restart from the datapath stage
    @(negedge clk);
    cdr_req_i = 1'b1;
    repeat (4) @(negedge clk);
    cdr_req_i = 1'b0;
    for (int i = 0; i < 400 && (cdr_rst_o || oob_rst_o); i++) @(negedge clk);
    cdr_req_i = 1'b1;
    @(negedge clk);
    cdr_req_i = 1'b0;
    rel = cyc;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    all_hi = cdr_rst_o && oob_rst_o && dp_rst_o && buf_rst_o;
    chk(all_hi, "R12 restart asserts all", all_hi, 1);
    wait_done("R12");
    chk(f_cdr - rel >= exp_lo() && f_cdr - rel <= exp_hi(), "R12 R4 restart window",
        f_cdr - rel, exp_lo());
    check_cascade("R12");

    // Constrained random full requests with random idle gaps
    for (int k = 0; k < 10; k++) begin
      repeat ($urandom % 40) @(negedge clk);
      full_req(1'($urandom % 2), 1 + int'($urandom % 20));
    end

    finish_run();
  end
endmodule